// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a supervision timer. A 16-bit down-counter loses one count on each pulse of a slow clock-enable input. When it reaches zero, the block raises a fault output that a system reset controller can act on. Software keeps the fault from happening by restarting the counter often enough. A restart is a write to a control word, and it is accepted only when the word carries the correct 8-bit key.

A restart must also arrive late enough. It is accepted only while the counter is at or below a programmed window threshold. A restart that comes too early is treated as a software error. It raises an error output and can optionally raise the fault output as well.

The mode word holds the reload value, the window threshold and the two fault enables. It can be written only once after reset, so runaway code cannot weaken the timer later. A status word reports the two event flags and the live count. Reading the status word clears the flags.

Top module: `wdog_top`

## Requirements
- R1: The 16-bit counter decrements by one on each clock cycle where `tick` is high. Once it reaches zero it holds at zero until it is reloaded.
- R2: A write to address 0 is a restart only when bits [31:24] equal 0xA5 and bit 0 is 1. A write with any other key value changes neither the counter nor the error flag.
- R3: The mode word at address 1 has four fields: reload in bits [11:0], window in bits [23:12], fault-on-underflow enable in bit 24, and fault-on-error enable in bit 25. Only the first write after reset is taken, and that write also loads the counter with the new reload value. Every later write changes neither the mode nor the counter. Reading address 1 returns the mode fields in the same positions.
- R4: A keyed restart while the counter is at or below the window value loads the counter with the reload value at the next clock edge. A keyed restart while the counter is above the window value leaves the counter unchanged and sets the error flag.
- R5: `errOut` is high while the error flag is set. `faultOut` is also high during that time if fault-on-error is enabled.
- R6: The tick that takes the counter from 1 to 0 sets the underflow flag. `faultOut` is high while the underflow flag is set and fault-on-underflow is enabled.
- R7: When `rdEn` is high with address 2, the next cycle's `rdData` holds the underflow flag in bit 0, the error flag in bit 1 and the counter in bits [31:16]. The read clears both flags. If a flag is being set in the same cycle as the read, the flag stays set.
- R8: After reset the counter is 0xFFF, reload and window are both 0xFFF, fault-on-underflow is enabled, fault-on-error is disabled, both flags are clear, and both outputs are low.
- R9: A keyed restart that is accepted in the same cycle as a tick takes priority, so the counter ends at the reload value and is not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow clock-enable; one decrement per high cycle |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 restart, 1 mode, 2 status) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| errOut | output | 1 | Early-restart error indication |
| faultOut | output | 1 | Watchdog fault (reset request) |

## Verification
The bench places restarts at the window threshold and at one count above it. A comparator written as strict-less-than would flag the boundary restart as an error, and an off-by-one on the other side would wrongly accept the restart at threshold plus one.

It issues a second mode write with different fields and a restart carrying a wrong key. A design that re-opens the mode register would move the counter or the readback, and a design with a loose key check would reload the counter.

It lets the counter run into zero and keeps ticking, then lines up a status read with the underflow tick. A design that wraps past zero would show a large count there, and one where the clear beats the set would lose the underflow event.

A tick that arrives together with an accepted restart must leave the counter at the reload value, not at one less.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic load;  // load counter with loadVal
    logic dec;   // decrement counter by one
  } dpStrobe_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FIELD_W = 12,
  parameter logic [FIELD_W-1:0] RST_RELOAD = 12'hFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [CNT_W-1:0]   loadVal,
  input  logic [FIELD_W-1:0] windowVal,
  output logic [CNT_W-1:0]   cnt,
  output logic               atZero,
  output logic               atOne,
  output logic               inWindow
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= CNT_W'(RST_RELOAD);
    end else if (strobe.load) begin
      cnt <= loadVal;
    end else if (strobe.dec) begin
      cnt <= cnt - CNT_ONE;
    end
  end

  always_comb begin
    atZero   = (cnt == '0);
    atOne    = (cnt == CNT_ONE);
    inWindow = (cnt <= CNT_W'(windowVal));
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FIELD_W = 12,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 8,
  parameter logic [KEY_W-1:0]   KEY        = 8'hA5,
  parameter logic [FIELD_W-1:0] RST_RELOAD = 12'hFFF,
  parameter logic [FIELD_W-1:0] RST_WINDOW = 12'hFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               atZero,
  input  logic               atOne,
  input  logic               inWindow,
  output dpStrobe_t          strobe,
  output logic [CNT_W-1:0]   loadVal,
  output logic [FIELD_W-1:0] reloadVal,
  output logic [FIELD_W-1:0] windowVal,
  output logic               uflowFaultEn,
  output logic               errFaultEn,
  output logic               modeLocked,
  output logic               uflowFlag,
  output logic               errFlag,
  output logic [DATA_W-1:0]  rdData
);
  localparam int WIN_LO    = FIELD_W;
  localparam int UF_EN_BIT = 2 * FIELD_W;
  localparam int ER_EN_BIT = 2 * FIELD_W + 1;
  localparam int MODE_PAD  = DATA_W - 2 * FIELD_W - 2;
  localparam int STAT_PAD  = DATA_W - CNT_W - 2;

  logic keyOk, restartReq, restartOk, restartBad, modeWr, statRead, setUflow;

  always_comb begin
    keyOk      = (wrData[DATA_W-1 -: KEY_W] == KEY);
    restartReq = wrEn && (addr == ADDR_CTRL) && keyOk && wrData[0];
    restartOk  = restartReq && inWindow;
    restartBad = restartReq && !inWindow;
    modeWr     = wrEn && (addr == ADDR_MODE) && !modeLocked;
    statRead   = rdEn && (addr == ADDR_STAT);

    strobe.load = restartOk || modeWr;
    strobe.dec  = tick && !atZero && !strobe.load;
    setUflow    = strobe.dec && atOne;
    loadVal     = modeWr ? CNT_W'(wrData[FIELD_W-1:0]) : CNT_W'(reloadVal);
  end

  // write-once mode register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal    <= RST_RELOAD;
      windowVal    <= RST_WINDOW;
      uflowFaultEn <= 1'b1;
      errFaultEn   <= 1'b0;
      modeLocked   <= 1'b0;
    end else if (modeWr) begin
      reloadVal    <= wrData[FIELD_W-1:0];
      windowVal    <= wrData[WIN_LO +: FIELD_W];
      uflowFaultEn <= wrData[UF_EN_BIT];
      errFaultEn   <= wrData[ER_EN_BIT];
      modeLocked   <= 1'b1;
    end
  end

  // event flags: a set in the same cycle as a clearing read wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      uflowFlag <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (setUflow)      uflowFlag <= 1'b1;
      else if (statRead) uflowFlag <= 1'b0;
      if (restartBad)    errFlag <= 1'b1;
      else if (statRead) errFlag <= 1'b0;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (addr)
        ADDR_MODE: rdData <= {{MODE_PAD{1'b0}}, errFaultEn, uflowFaultEn, windowVal, reloadVal};
        ADDR_STAT: rdData <= {cnt, {STAT_PAD{1'b0}}, errFlag, uflowFlag};
        default:   rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int FIELD_W = 12,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 8,
  parameter logic [KEY_W-1:0]   KEY        = 8'hA5,
  parameter logic [FIELD_W-1:0] RST_RELOAD = 12'hFFF,
  parameter logic [FIELD_W-1:0] RST_WINDOW = 12'hFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              errOut,
  output logic              faultOut
);
  dpStrobe_t          strobe;
  logic [CNT_W-1:0]   cntVal, loadVal;
  logic [FIELD_W-1:0] reloadVal, windowVal;
  logic atZero, atOne, inWindow;
  logic uflowFaultEn, errFaultEn, modeLocked, uflowFlag, errFlag;

  wdog_ctrl #(
    .CNT_W(CNT_W), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .KEY(KEY), .RST_RELOAD(RST_RELOAD), .RST_WINDOW(RST_WINDOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .cnt(cntVal), .atZero(atZero),
    .atOne(atOne), .inWindow(inWindow), .strobe(strobe), .loadVal(loadVal),
    .reloadVal(reloadVal), .windowVal(windowVal), .uflowFaultEn(uflowFaultEn),
    .errFaultEn(errFaultEn), .modeLocked(modeLocked), .uflowFlag(uflowFlag),
    .errFlag(errFlag), .rdData(rdData)
  );

  wdog_datapath #(
    .CNT_W(CNT_W), .FIELD_W(FIELD_W), .RST_RELOAD(RST_RELOAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal),
    .windowVal(windowVal), .cnt(cntVal), .atZero(atZero), .atOne(atOne),
    .inWindow(inWindow)
  );

  always_comb begin
    errOut   = errFlag;
    faultOut = (uflowFlag && uflowFaultEn) || (errFlag && errFaultEn);
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W   = 16,
  parameter int FIELD_W = 12,
  parameter int DATA_W  = 32,
  parameter int KEY_W   = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               wrEn,
  input logic               rdEn,
  input logic [1:0]         addr,
  input logic [DATA_W-1:0]  wrData,
  input logic               errOut,
  input logic               faultOut,
  input logic [CNT_W-1:0]   cntVal,
  input logic [FIELD_W-1:0] reloadVal,
  input logic [FIELD_W-1:0] windowVal,
  input logic               uflowFaultEn,
  input logic               modeLocked
);
  logic keyed;
  assign keyed = wrEn && (addr == 2'd0) && (wrData[DATA_W-1 -: KEY_W] == KEY) && wrData[0];

  p_decrement_r1: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && cntVal != '0) |=> (cntVal == $past(cntVal) - 1'b1));

  p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == '0 && !wrEn) |=> (cntVal == '0));

  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0 && wrData[DATA_W-1 -: KEY_W] != KEY && !tick && !rdEn)
      |=> ($stable(cntVal) && $stable(errOut)));

  p_mode_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> (modeLocked && $stable(reloadVal) && $stable(windowVal)));

  p_early_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyed && cntVal > CNT_W'(windowVal)) |=> (errOut && $stable(cntVal)));

  p_restart_ok_r9: assert property (@(posedge clk) disable iff (!rstN)
    (keyed && cntVal <= CNT_W'(windowVal)) |=> (cntVal == CNT_W'($past(reloadVal))));

  p_uflow_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && cntVal == CNT_W'(1) && uflowFaultEn) |=> faultOut);
endmodule

bind wdog_top wdog_checker #(
  .CNT_W(CNT_W), .FIELD_W(FIELD_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY)
) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .errOut(errOut), .faultOut(faultOut), .cntVal(cntVal),
  .reloadVal(reloadVal), .windowVal(windowVal), .uflowFaultEn(uflowFaultEn),
  .modeLocked(modeLocked)
);

// File: tb/wdog_top_test.sv
`timescale 1ns/1ps
module wdog_top_test;
  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic errOut, faultOut;
  int checks = 0, failures = 0;

  localparam logic [31:0] RESTART  = 32'hA500_0001;
  localparam logic [31:0] MODE_A   = 32'd20 | (32'd8 << 12) | (32'd1 << 24) | (32'd1 << 25);
  localparam logic [31:0] MODE_B   = 32'd100 | (32'd50 << 12);

  always #2 clk = ~clk;

  wdog_top uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .errOut(errOut), .faultOut(faultOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d, input logic withTick = 1'b0);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; tick = withTick;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0; wrData = '0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d, input logic withTick = 1'b0);
    @(negedge clk);
    rdEn = 1'b1; addr = a; tick = withTick;
    @(negedge clk);
    rdEn = 1'b0; tick = 1'b0;
    d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic statusIs(input string req, input logic [15:0] c, input logic e, input logic u);
    logic [31:0] d;
    busRead(2'd2, d);
    check(req, d, {c, 14'd0, e, u});
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R8 errOut", {31'd0, errOut}, 32'd0);
    check("R8 faultOut", {31'd0, faultOut}, 32'd0);
    statusIs("R8 status", 16'h0FFF, 1'b0, 1'b0);
    busRead(2'd1, d);
    check("R8 mode default", d, 32'h01FF_FFFF);
  endtask

  task automatic testDecrement();
    ticks(5);
    statusIs("R1 decrement", 16'h0FFA, 1'b0, 1'b0);
  endtask

  task automatic testKey();
    busWrite(2'd0, 32'h5A00_0001);
    statusIs("R2 wrong key ignored", 16'h0FFA, 1'b0, 1'b0);
    busWrite(2'd0, 32'hA500_0000);
    statusIs("R2 key without restart bit", 16'h0FFA, 1'b0, 1'b0);
    busWrite(2'd0, RESTART);
    statusIs("R4 default window restart", 16'h0FFF, 1'b0, 1'b0);
  endtask

  task automatic testModeOnce();
    logic [31:0] d;
    busWrite(2'd1, MODE_A);
    busRead(2'd1, d);
    check("R3 mode readback", d, MODE_A);
    statusIs("R3 mode write reloads", 16'd20, 1'b0, 1'b0);
    busWrite(2'd1, MODE_B);
    busRead(2'd1, d);
    check("R3 second write ignored", d, MODE_A);
    statusIs("R3 counter kept after second write", 16'd20, 1'b0, 1'b0);
  endtask

  task automatic testWindow();
    busWrite(2'd0, RESTART);
    check("R5 errOut early restart", {31'd0, errOut}, 32'd1);
    check("R5 faultOut on error", {31'd0, faultOut}, 32'd1);
    statusIs("R4 early restart no reload", 16'd20, 1'b1, 1'b0);
    statusIs("R7 error cleared by read", 16'd20, 1'b0, 1'b0);
    check("R5 errOut cleared", {31'd0, errOut}, 32'd0);
    ticks(11);
    busWrite(2'd0, RESTART);
    statusIs("R4 window plus one rejected", 16'd9, 1'b1, 1'b0);
    ticks(1);
    busWrite(2'd0, RESTART);
    statusIs("R4 window boundary accepted", 16'd20, 1'b0, 1'b0);
  endtask

  task automatic testTickRestart();
    ticks(12);
    busWrite(2'd0, RESTART, 1'b1);
    statusIs("R9 restart beats tick", 16'd20, 1'b0, 1'b0);
  endtask

  task automatic testUnderflow();
    logic [31:0] d;
    ticks(20);
    check("R6 faultOut at zero", {31'd0, faultOut}, 32'd1);
    check("R6 no errOut at zero", {31'd0, errOut}, 32'd0);
    ticks(3);
    statusIs("R6 underflow flag, R1 hold", 16'd0, 1'b0, 1'b1);
    check("R7 fault released by read", {31'd0, faultOut}, 32'd0);
    busWrite(2'd0, RESTART);
    ticks(19);
    busRead(2'd2, d, 1'b1);
    check("R7 read sees pre-set state", d, {16'd1, 16'd0});
    statusIs("R7 set wins over clear", 16'd0, 1'b0, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testDecrement();
        testKey();
        testModeOnce();
        testWindow();
        testTickRestart();
        testUnderflow();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule